// File: doc/BRIEF.md
# Microphone Power State Controller

This block tracks the power state of a digital microphone. It starts with a cold warm-up and then moves between normal operation, standby and power-down. It runs entirely on a free-running reference clock. The serial bit clock (SCK) and the enable pin are brought into that domain through synchronizers. Each warm-up is timed by counting rising edges of SCK. The block decides that SCK has stopped when no rising edge has arrived for a programmable number of reference cycles.

Each way back to normal operation has its own latency, and each is a power of two in SCK cycles:

- The cold start after power-on reset takes the longest.
- A resume from power-down is shorter than the cold start.
- A resume from standby, after SCK restarts, is the shortest.

A low enable pin sends the block to power-down. If this happens during any warm-up, that count is abandoned. The block moves to standby only from normal operation, and it never moves directly between standby and power-down. The `operational_o` output is meant to gate real sample data onto the serial output, and `powered_down_o` flags the power-down state.

Top module: `mic_power_seq`

## Requirements
- R1: While `por_n` is low, and directly after it rises, `state_o` is 0 (cold warm-up), and `operational_o` and `powered_down_o` are both 0.
- R2: In cold warm-up with the enable pin high, `state_o` becomes 1 (normal) after exactly 2^COLD_LOG2 SCK rising edges. Before that it stays 0.
- R3: In normal state with the enable pin high, once no SCK rising edge has been seen for IDLE_LIMIT reference cycles, `state_o` becomes 2 (standby).
- R4: In standby, the first SCK rising edge moves `state_o` to 3 (standby resume). Exactly 2^STBY_LOG2 further rising edges then move it to 1 (normal).
- R5: A low enable pin moves the block from cold warm-up (0), normal (1), standby resume (3) or power-down resume (5) to 4 (power-down), whatever SCK is doing. Any partial warm-up count is abandoned.
- R6: In power-down, the first SCK rising edge seen while the enable pin is high moves `state_o` to 5 (power-down resume). Exactly 2^PDN_LOG2 further rising edges then move it to 1 (normal).
- R7: In standby a low enable pin has no effect, and the state stays 2 until SCK restarts. In power-down, a stopped or running SCK with the enable pin low leaves the state at 4.
- R8: `operational_o` is 1 only when `state_o` is 1. `powered_down_o` is 1 only when `state_o` is 4.
- R9: A warm-up count pauses while SCK is stopped and keeps the edges already counted. The edges before and after a pause add up to the required total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock. All state is held in this domain. |
| por_n | input | 1 | Asynchronous active-low power-on reset. |
| sck | input | 1 | Serial bit clock, asynchronous to `ref_clk`. |
| chip_en | input | 1 | Microphone enable pin, asynchronous. |
| state_o | output | 3 | Current state code: 0 cold, 1 normal, 2 standby, 3 standby resume, 4 power-down, 5 power-down resume. |
| operational_o | output | 1 | High in normal state. Gates real data onto the serial output. |
| powered_down_o | output | 1 | High in power-down state. |

## Verification
The properties assume that SCK is sampled by the reference clock without losing edges. This means each SCK phase must last at least two reference cycles, and SCK must count as running while its edge gaps stay below IDLE_LIMIT. The stimulus drives SCK with phases of two reference cycles each, which gives a rising edge every four cycles against an idle limit of sixteen. It changes the enable pin only while SCK is quiet or between whole SCK periods, and it lets every transition settle for eight reference cycles before sampling. The assertions also assume that the enable pin never falls in the same cycle in which SCK is declared stopped, and the stimulus never lines those two events up.

// File: rtl/mpsc_pkg.sv
package mpsc_pkg;
   typedef enum logic [2:0] {
      PS_COLD      = 3'd0,
      PS_NORMAL    = 3'd1,
      PS_STBY      = 3'd2,
      PS_STBY_WAKE = 3'd3,
      PS_PDN       = 3'd4,
      PS_PDN_WAKE  = 3'd5
   } pwr_state_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/mpsc_sync.sv
module mpsc_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= RST_VAL;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mpsc_activity.sv
module mpsc_activity #(
   parameter int IDLE_LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_s,
   output logic rise,
   output logic stopped
);
   localparam int IW = $clog2(IDLE_LIMIT + 1);
   localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_LIMIT - 1);

   logic          sck_d;
   logic [IW-1:0] idle_cnt;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;

   assign rise = sck_s & ~sck_d;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         idle_cnt <= '0;
         stopped  <= 1'b1;
      end else if (rise) begin
         idle_cnt <= '0;
         stopped  <= 1'b0;
      end else if (!stopped) begin
         if (idle_cnt == IDLE_LAST) stopped <= 1'b1;
         else                       idle_cnt <= idle_cnt + 1'b1;
      end
endmodule

// File: rtl/mpsc_fsm.sv
module mpsc_fsm
   import mpsc_pkg::*;
#(
   parameter int COLD_LOG2 = 18,
   parameter int STBY_LOG2 = 14,
   parameter int PDN_LOG2  = 17
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       rise,
   input  logic       stopped,
   output pwr_state_e state,
   output logic       operational,
   output logic       powered_down
);
   localparam int CW = max3(COLD_LOG2, STBY_LOG2, PDN_LOG2) + 1;
   localparam logic [CW-1:0] T_COLD = CW'((64'd1 << COLD_LOG2) - 1);
   localparam logic [CW-1:0] T_STBY = CW'((64'd1 << STBY_LOG2) - 1);
   localparam logic [CW-1:0] T_PDN  = CW'((64'd1 << PDN_LOG2) - 1);

   pwr_state_e    state_n;
   logic [CW-1:0] cnt;
   logic          counting;
   logic [CW-1:0] target;

   always_comb begin
      counting = 1'b0;
      target   = T_COLD;
      case (state)
         PS_COLD:      begin counting = 1'b1; target = T_COLD; end
         PS_STBY_WAKE: begin counting = 1'b1; target = T_STBY; end
         PS_PDN_WAKE:  begin counting = 1'b1; target = T_PDN;  end
         default:      ;
      endcase
   end

   always_comb begin
      state_n = state;
      case (state)
         PS_COLD, PS_STBY_WAKE, PS_PDN_WAKE:
            if (!en)                        state_n = PS_PDN;
            else if (rise && cnt == target) state_n = PS_NORMAL;
         PS_NORMAL:
            if (!en)          state_n = PS_PDN;
            else if (stopped) state_n = PS_STBY;
         PS_STBY:
            if (rise) state_n = PS_STBY_WAKE;
         PS_PDN:
            if (en && rise) state_n = PS_PDN_WAKE;
         default: state_n = PS_COLD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         state        <= PS_COLD;
         cnt          <= '0;
         operational  <= 1'b0;
         powered_down <= 1'b0;
      end else begin
         state        <= state_n;
         operational  <= (state_n == PS_NORMAL);
         powered_down <= (state_n == PS_PDN);
         if (state_n != state)       cnt <= '0;
         else if (counting && rise)  cnt <= cnt + 1'b1;
      end
endmodule

// File: rtl/mic_power_seq.sv
module mic_power_seq
   import mpsc_pkg::*;
#(
   parameter int COLD_LOG2   = 18,
   parameter int STBY_LOG2   = 14,
   parameter int PDN_LOG2    = 17,
   parameter int IDLE_LIMIT  = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic       ref_clk,
   input  logic       por_n,
   input  logic       sck,
   input  logic       chip_en,
   output logic [2:0] state_o,
   output logic       operational_o,
   output logic       powered_down_o
);
   generate
      if (COLD_LOG2 < 1 || STBY_LOG2 < 1 || PDN_LOG2 < 1 || COLD_LOG2 > 40)
         $error("mic_power_seq: wake-up exponents out of range");
      if (IDLE_LIMIT < 4)
         $error("mic_power_seq: IDLE_LIMIT must be at least 4");
      if (SYNC_STAGES < 2)
         $error("mic_power_seq: SYNC_STAGES must be at least 2");
   endgenerate

   logic       sck_sync;
   logic       en_sync;
   logic       sck_rise;
   logic       sck_stopped;
   pwr_state_e cur_state;

   mpsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
      .clk(ref_clk), .rst_n(por_n), .d(sck), .q(sck_sync)
   );

   mpsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_en_sync (
      .clk(ref_clk), .rst_n(por_n), .d(chip_en), .q(en_sync)
   );

   mpsc_activity #(.IDLE_LIMIT(IDLE_LIMIT)) u_act (
      .clk(ref_clk), .rst_n(por_n), .sck_s(sck_sync),
      .rise(sck_rise), .stopped(sck_stopped)
   );

   mpsc_fsm #(.COLD_LOG2(COLD_LOG2), .STBY_LOG2(STBY_LOG2), .PDN_LOG2(PDN_LOG2)) u_fsm (
      .clk(ref_clk), .rst_n(por_n), .en(en_sync), .rise(sck_rise),
      .stopped(sck_stopped), .state(cur_state),
      .operational(operational_o), .powered_down(powered_down_o)
   );

   assign state_o = cur_state;
endmodule

// File: rtl/mic_power_seq_chk.sv
module mic_power_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] state,
   input logic       operational,
   input logic       powered_down,
   input logic       en_s,
   input logic       sck_rise,
   input logic       sck_stopped
);
   // R5: a low enable leaves every state except standby for power-down
   a_r5_low_en_pdn: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_s && (state == 3'd0 || state == 3'd1 || state == 3'd3 || state == 3'd5))
      |=> state == 3'd4);

   // R3: normal with SCK stopped and enable high goes to standby
   a_r3_stop_to_stby: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 3'd1 && en_s && sck_stopped) |=> state == 3'd2);

   // R7: standby holds until an SCK edge, whatever the enable pin does
   a_r7_stby_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 3'd2 && !sck_rise) |=> state == 3'd2);

   // R7: power-down holds unless enable is high and SCK ticks
   a_r7_pdn_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 3'd4 && !(en_s && sck_rise)) |=> state == 3'd4);

   // R8: flags follow the state code
   a_r8_oper_flag: assert property (@(posedge clk) disable iff (!rst_n)
      operational == (state == 3'd1));
   a_r8_pdn_flag: assert property (@(posedge clk) disable iff (!rst_n)
      powered_down == (state == 3'd4));

   // R1: only defined state codes appear
   a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      state <= 3'd5);
endmodule

bind mic_power_seq mic_power_seq_chk u_chk (
   .clk(ref_clk), .rst_n(por_n), .state(state_o),
   .operational(operational_o), .powered_down(powered_down_o),
   .en_s(en_sync), .sck_rise(sck_rise), .sck_stopped(sck_stopped)
);

// File: tb/sim_mic_power_seq.sv
module sim_mic_power_seq;
   localparam int CLK_PERIOD = 10;
   localparam int COLD_LOG2 = 4, STBY_LOG2 = 2, PDN_LOG2 = 3, IDLE = 16;
   localparam int N_COLD = 1 << COLD_LOG2;
   localparam int N_STBY = 1 << STBY_LOG2;
   localparam int N_PDN  = 1 << PDN_LOG2;
   localparam logic [2:0] S_COLD = 3'd0, S_NORM = 3'd1, S_STBY = 3'd2,
                          S_SWAKE = 3'd3, S_PDN = 3'd4, S_PWAKE = 3'd5;

   logic clk = 1'b0, por_n = 1'b0, sck = 1'b0, en = 1'b1;
   logic [2:0] st;
   logic oper, pdn;
   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mic_power_seq #(.COLD_LOG2(COLD_LOG2), .STBY_LOG2(STBY_LOG2), .PDN_LOG2(PDN_LOG2),
                   .IDLE_LIMIT(IDLE), .SYNC_STAGES(2)) u0 (
      .ref_clk(clk), .por_n(por_n), .sck(sck), .chip_en(en),
      .state_o(st), .operational_o(oper), .powered_down_o(pdn));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         sck = 1'b1; waitc(2);
         sck = 1'b0; waitc(2);
      end
   endtask

   task automatic do_reset();
      por_n = 1'b0; sck = 1'b0; en = 1'b1;
      waitc(4);
      por_n = 1'b1;
      waitc(4);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1 reset state
      waitc(2);
      chk("R1 state in reset", st, S_COLD);
      chk("R1 oper in reset", oper, 0);
      do_reset();
      chk("R1 state after reset", st, S_COLD);
      chk("R1 pdn after reset", pdn, 0);

      // R2 sweep over every edge count up to the cold limit
      for (int k = 0; k <= N_COLD; k++) begin
         do_reset();
         pulses(k);
         waitc(8);
         chk("R2 cold count", st, (k == N_COLD) ? S_NORM : S_COLD);
         chk("R8 oper vs cold", oper, (k == N_COLD) ? 1 : 0);
      end

      // R9 pause keeps count
      do_reset();
      pulses(10);
      waitc(60);
      chk("R9 paused still cold", st, S_COLD);
      pulses(N_COLD - 11);
      waitc(8);
      chk("R9 one short", st, S_COLD);
      pulses(1);
      waitc(8);
      chk("R9 total reached", st, S_NORM);
      chk("R8 oper normal", oper, 1);
      chk("R8 pdn normal", pdn, 0);

      // R3 SCK stop -> standby
      waitc(30);
      chk("R3 standby", st, S_STBY);
      chk("R8 oper standby", oper, 0);

      // R7 enable low ignored in standby
      en = 1'b0;
      waitc(20);
      chk("R7 standby keeps", st, S_STBY);
      chk("R7 no pdn flag", pdn, 0);
      en = 1'b1;
      waitc(8);

      // R4 standby resume sweep
      pulses(1);
      waitc(8);
      chk("R4 resume entered", st, S_SWAKE);
      for (int k = 1; k <= N_STBY; k++) begin
         pulses(1);
         waitc(8);
         chk("R4 resume count", st, (k == N_STBY) ? S_NORM : S_SWAKE);
      end

      // R5 normal -> power-down
      en = 1'b0;
      waitc(8);
      chk("R5 normal to pdn", st, S_PDN);
      chk("R8 pdn flag", pdn, 1);
      chk("R8 oper pdn", oper, 0);

      // R7 power-down holds
      waitc(40);
      chk("R7 pdn idle", st, S_PDN);
      pulses(5);
      waitc(8);
      chk("R7 pdn sck running en low", st, S_PDN);

      // R6 power-down resume sweep
      en = 1'b1;
      waitc(8);
      chk("R6 en high no edge", st, S_PDN);
      pulses(1);
      waitc(8);
      chk("R6 resume entered", st, S_PWAKE);
      for (int k = 1; k <= N_PDN; k++) begin
         pulses(1);
         waitc(8);
         chk("R6 resume count", st, (k == N_PDN) ? S_NORM : S_PWAKE);
      end

      // R5 abandon power-down resume, count restarts
      en = 1'b0; waitc(8);
      en = 1'b1; waitc(8);
      pulses(1); waitc(8);
      pulses(3);
      en = 1'b0; waitc(8);
      chk("R5 pdn resume abandoned", st, S_PDN);
      en = 1'b1; waitc(8);
      pulses(1); waitc(8);
      pulses(N_PDN - 1); waitc(8);
      chk("R5 count restarted", st, S_PWAKE);
      pulses(1); waitc(8);
      chk("R5 full count after restart", st, S_NORM);

      // R5 abandon standby resume -> power-down, not standby
      waitc(30);
      chk("R3 standby again", st, S_STBY);
      pulses(1); waitc(8);
      en = 1'b0; waitc(8);
      chk("R5 standby resume to pdn", st, S_PDN);

      // R5 cold warm-up abandoned
      do_reset();
      pulses(3);
      en = 1'b0; waitc(8);
      chk("R5 cold to pdn", st, S_PDN);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule